// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry Out

This block sits between the register read stage and the ALU. It takes the 32-bit second operand and shifts or rotates it: logical left, logical right, arithmetic right, rotate right, or a one-bit rotate through the incoming carry flag. It returns the shifted word and a shifter carry-out that the flag logic can load into C. The shift distance comes from one of two sources. It is either a 5-bit constant held in the instruction, or the low byte of a register, so distances from 0 to 255 are possible.

The two amount sources read the value zero in different ways. A register distance of zero leaves the operand and the carry untouched. An immediate zero is reused as an encoding: for logical and arithmetic right shifts it means a distance of 32, and for rotate right it selects the rotate through carry. Register distances of 32 or more follow fixed rules for result and carry. One request is accepted per cycle, and each result appears one clock later in a registered output stage.

Top module: `opnd_shifter`

## Requirements
- R1: While `rst` is high, at each rising clock edge `out_valid`, `out_result` and `out_carry` are cleared to 0.
- R2: A request taken with `in_valid` high produces its result with `out_valid` high exactly one clock later. A cycle with `in_valid` low gives `out_valid` low on the next cycle, and `out_result`/`out_carry` keep their previous values.
- R3: `in_op` encodes the shift type: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. When `in_use_reg` is 1 the distance is `in_reg_amt`; when it is 0 the distance is `in_imm_amt`.
- R4: A logical left shift by n in 1..31 fills zeros at bit 0, and the carry-out is the last bit pushed past bit 31 (operand bit 32-n).
- R5: A logical right shift by n in 1..31 fills zeros at bit 31, and the carry-out is the last bit pushed past bit 0 (operand bit n-1).
- R6: An arithmetic right shift by n in 1..31 copies operand bit 31 into the n vacated upper bits, and the carry-out is operand bit n-1.
- R7: A rotate right by a distance whose low five bits are nonzero moves the bits leaving bit 0 into bit 31. The carry-out equals bit 31 of the result.
- R8: An immediate rotate right with distance 0 is a one-bit rotate through carry: result = {in_carry, operand[31:1]}, carry-out = operand bit 0.
- R9: A register distance of 0, for any shift type, and an immediate logical left shift by 0 both pass the operand through unchanged, with carry-out equal to `in_carry`.
- R10: An immediate logical right or arithmetic right shift with distance 0 acts as a shift by 32.
- R11: A logical left or logical right shift by exactly 32 gives 0, with carry-out equal to operand bit 0 (left) or bit 31 (right). Any distance above 32 gives 0 with carry-out 0.
- R12: An arithmetic right shift by 32 or more sets every result bit and the carry-out to operand bit 31.
- R13: A register-sourced rotate right uses the distance modulo 32. A nonzero multiple of 32 leaves the operand unchanged, with carry-out equal to operand bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe for this cycle |
| in_operand | input | 32 | Operand word to be shifted |
| in_op | input | 2 | Shift type (0 left, 1 right, 2 arithmetic right, 3 rotate) |
| in_use_reg | input | 1 | 1 selects the register distance, 0 selects the immediate |
| in_imm_amt | input | 5 | Immediate distance |
| in_reg_amt | input | 8 | Low byte of the distance register |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Shifted operand |
| out_carry | output | 1 | Shifter carry-out |

## Verification
The properties assume that every input is at a known level whenever `in_valid` is high, and that `rst` is held for at least one edge before the first request. The properties that use `$past` of the operand and carry also rely on those inputs being settled in the cycle the request is captured. The stimulus holds `rst` for several edges and changes every input only on the falling clock edge. It drives `in_valid` low between bursts and never leaves a field undriven. The random requests cover all four type codes, both distance sources and the full 8-bit register distance range, so the properties for distances of 32 and above are triggered as well.

// File: rtl/opnd_shift_pkg.sv
package opnd_shift_pkg;

    localparam int AMT_W = 8;

    typedef enum logic [1:0] {
        OP_LSL = 2'd0,
        OP_LSR = 2'd1,
        OP_ASR = 2'd2,
        OP_ROR = 2'd3
    } shift_op_e;

    typedef enum logic [2:0] {
        K_PASS,
        K_LSL,
        K_LSR,
        K_ASR,
        K_ROR,
        K_RRX
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e      kind;
        logic [AMT_W-1:0] amt;
    } shift_req_t;

    function automatic logic [AMT_W-1:0] widen_imm(input logic [AMT_W-1:0] v);
        return v;
    endfunction

endpackage

// File: rtl/opnd_shift_dec.sv
module opnd_shift_dec
    import opnd_shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int IMM_W    = $clog2(DATA_W)
) (
    input  logic [1:0]           op,
    input  logic                 use_reg,
    input  logic [IMM_W-1:0]     imm_amt,
    input  logic [REG_AMT_W-1:0] reg_amt,
    output shift_req_t           req
);

    localparam logic [AMT_W-1:0] FULL_AMT = AMT_W'(DATA_W);

    shift_op_e        op_e;
    logic [AMT_W-1:0] imm_ext;
    logic [AMT_W-1:0] reg_ext;
    shift_kind_e      base_kind;

    assign op_e    = shift_op_e'(op);
    assign imm_ext = widen_imm(AMT_W'(imm_amt));
    assign reg_ext = AMT_W'(reg_amt);

    always_comb begin
        unique case (op_e)
            OP_LSL:  base_kind = K_LSL;
            OP_LSR:  base_kind = K_LSR;
            OP_ASR:  base_kind = K_ASR;
            default: base_kind = K_ROR;
        endcase
    end

    always_comb begin
        req.kind = base_kind;
        req.amt  = use_reg ? reg_ext : imm_ext;
        if (use_reg) begin
            if (reg_ext == '0) begin
                req.kind = K_PASS;
            end
        end else if (imm_ext == '0) begin
            unique case (op_e)
                OP_LSL:  req.kind = K_PASS;
                OP_LSR,
                OP_ASR:  req.amt  = FULL_AMT;
                default: req.kind = K_RRX;
            endcase
        end
    end

endmodule

// File: rtl/opnd_shift_core.sv
module opnd_shift_core
    import opnd_shift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int IMM_W = $clog2(DATA_W)
) (
    input  shift_req_t        req,
    input  logic [DATA_W-1:0] x,
    input  logic              cin,
    output logic [DATA_W-1:0] y,
    output logic              cout
);

    logic [DATA_W:0]    lsl_w;
    logic [DATA_W:0]    lsr_w;
    logic [DATA_W:0]    asr_w;
    logic [IMM_W-1:0]   rot_n;
    logic [DATA_W-1:0]  rot_v;

    // The extra bit beside the word catches the last bit shifted out.
    assign lsl_w = {1'b0, x} << req.amt;
    assign lsr_w = {x, 1'b0} >> req.amt;
    assign asr_w = $signed({x, 1'b0}) >>> req.amt;
    assign rot_n = req.amt[IMM_W-1:0];
    assign rot_v = (x >> rot_n) | (x << (DATA_W - int'(rot_n)));

    always_comb begin
        unique case (req.kind)
            K_LSL: begin
                y    = lsl_w[DATA_W-1:0];
                cout = lsl_w[DATA_W];
            end
            K_LSR: begin
                y    = lsr_w[DATA_W:1];
                cout = lsr_w[0];
            end
            K_ASR: begin
                y    = asr_w[DATA_W:1];
                cout = asr_w[0];
            end
            K_ROR: begin
                y    = rot_v;
                cout = rot_v[DATA_W-1];
            end
            K_RRX: begin
                y    = {cin, x[DATA_W-1:1]};
                cout = x[0];
            end
            default: begin
                y    = x;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opnd_shift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int IMM_W    = $clog2(DATA_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_W-1:0]    in_operand,
    input  logic [1:0]           in_op,
    input  logic                 in_use_reg,
    input  logic [IMM_W-1:0]     in_imm_amt,
    input  logic [REG_AMT_W-1:0] in_reg_amt,
    input  logic                 in_carry,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_result,
    output logic                 out_carry
);

    shift_req_t        req;
    logic [DATA_W-1:0] shifted;
    logic              shift_c;

    opnd_shift_dec #(
        .DATA_W    (DATA_W),
        .REG_AMT_W (REG_AMT_W)
    ) u_dec (
        .op      (in_op),
        .use_reg (in_use_reg),
        .imm_amt (in_imm_amt),
        .reg_amt (in_reg_amt),
        .req     (req)
    );

    opnd_shift_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .req  (req),
        .x    (in_operand),
        .cin  (in_carry),
        .y    (shifted),
        .cout (shift_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_carry  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= shifted;
                out_carry  <= shift_c;
            end
        end
    end

endmodule

// File: rtl/opnd_shift_chk.sv
module opnd_shift_chk #(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    localparam int IMM_W    = $clog2(DATA_W)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [DATA_W-1:0]    in_operand,
    input logic [1:0]           in_op,
    input logic                 in_use_reg,
    input logic [IMM_W-1:0]     in_imm_amt,
    input logic [REG_AMT_W-1:0] in_reg_amt,
    input logic                 in_carry,
    input logic                 out_valid,
    input logic [DATA_W-1:0]    out_result,
    input logic                 out_carry
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && !out_carry));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_carry)));

    // R7
    ror_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd3 &&
         (in_use_reg ? (in_reg_amt[IMM_W-1:0] != '0) : (in_imm_amt != '0)))
        |=> (out_carry == out_result[DATA_W-1]));

    // R8
    rrx_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_use_reg && in_op == 2'd3 && in_imm_amt == '0)
        |=> (out_result == {$past(in_carry), $past(in_operand[DATA_W-1:1])} &&
             out_carry == $past(in_operand[0])));

    // R9
    reg_zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_use_reg && in_reg_amt == '0)
        |=> (out_result == $past(in_operand) && out_carry == $past(in_carry)));

    // R11
    far_logical_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_use_reg && in_op inside {2'd0, 2'd1} && in_reg_amt > DATA_W)
        |=> (out_result == '0 && !out_carry));

    // R12
    asr_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_use_reg && in_op == 2'd2 && in_reg_amt >= DATA_W)
        |=> (out_result == {DATA_W{$past(in_operand[DATA_W-1])}} &&
             out_carry == $past(in_operand[DATA_W-1])));

endmodule

bind opnd_shifter opnd_shift_chk #(
    .DATA_W    (DATA_W),
    .REG_AMT_W (REG_AMT_W)
) u_chk (.*);

// File: tb/tb_opnd_shifter.sv
module tb_opnd_shifter;

    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_operand = '0;
    logic [1:0]  in_op = '0;
    logic        in_use_reg = 1'b0;
    logic [4:0]  in_imm_amt = '0;
    logic [7:0]  in_reg_amt = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_carry;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        c;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] last_res = '0;
    logic        last_c = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_shifter dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_operand (in_operand),
        .in_op      (in_op),
        .in_use_reg (in_use_reg),
        .in_imm_amt (in_imm_amt),
        .in_reg_amt (in_reg_amt),
        .in_carry   (in_carry),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_carry  (out_carry)
    );

    // Bit-serial reference: one single-bit step per unit of distance.
    function automatic logic [32:0] ref_shift(input logic [1:0] op, input logic use_reg,
                                              input logic [4:0] imm, input logic [7:0] ramt,
                                              input logic [31:0] x, input logic cin);
        int          n;
        logic [31:0] v;
        logic        c;
        v = x;
        c = cin;
        if (use_reg) begin
            n = int'(ramt);
        end else begin
            n = int'(imm);
            if (n == 0) begin
                if (op == 2'd1 || op == 2'd2) n = 32;
                else if (op == 2'd3) return {x[0], cin, x[31:1]};
            end
        end
        for (int i = 0; i < n; i++) begin
            case (op)
                2'd0: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'd1: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'd2: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] act_r, input logic act_c,
                         input logic [31:0] exp_r, input logic exp_c);
        n_checks++;
        if (act_r !== exp_r || act_c !== exp_c) begin
            n_fail++;
            $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
                     tag, act_r, act_c, exp_r, exp_c);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] op, input logic use_reg,
                         input logic [4:0] imm, input logic [7:0] ramt,
                         input logic [31:0] x, input logic cin);
        logic [32:0] e;
        exp_t        item;
        @(negedge clk);
        in_valid   = 1'b1;
        in_op      = op;
        in_use_reg = use_reg;
        in_imm_amt = imm;
        in_reg_amt = ramt;
        in_operand = x;
        in_carry   = cin;
        e = ref_shift(op, use_reg, imm, ramt, x, cin);
        item.res = e[31:0];
        item.c   = e[32];
        item.tag = tag;
        last_res = e[31:0];
        last_c   = e[32];
        sb_q.push_back(item);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            in_operand = 32'hDEAD_BEEF;
            in_carry   = ~in_carry;
        end
    endtask

    // Monitor: pops the scoreboard on every valid result.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2: unexpected result=%h carry=%b expected no output",
                         out_result, out_carry);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(it.tag, out_result, out_carry, it.res, it.c);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1", out_result, out_carry, 32'h0, 1'b0);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out_valid=%b expected 0", out_valid);
        end
        @(negedge clk);
        rst = 1'b0;

        // R3 / R4: logical left, immediate and register
        drive("R4", 2'd0, 1'b0, 5'd4,  8'd0,  32'h1800_0001, 1'b0);
        drive("R4", 2'd0, 1'b1, 5'd0,  8'd31, 32'h0000_0003, 1'b0);
        drive("R3", 2'd0, 1'b1, 5'd9,  8'd1,  32'h8000_0000, 1'b0);
        // R5
        drive("R5", 2'd1, 1'b0, 5'd8,  8'd0,  32'h1234_5680, 1'b0);
        drive("R5", 2'd1, 1'b1, 5'd0,  8'd1,  32'h0000_0001, 1'b0);
        // R6
        drive("R6", 2'd2, 1'b0, 5'd4,  8'd0,  32'h8000_0018, 1'b0);
        drive("R6", 2'd2, 1'b1, 5'd0,  8'd31, 32'h7FFF_FFFF, 1'b1);
        // R7
        drive("R7", 2'd3, 1'b0, 5'd1,  8'd0,  32'h0000_0001, 1'b0);
        drive("R7", 2'd3, 1'b1, 5'd0,  8'd8,  32'h1234_56AB, 1'b0);
        // R8
        drive("R8", 2'd3, 1'b0, 5'd0,  8'd0,  32'h0000_0003, 1'b1);
        drive("R8", 2'd3, 1'b0, 5'd0,  8'd0,  32'h8000_0000, 1'b0);
        // R9
        drive("R9", 2'd0, 1'b0, 5'd0,  8'd0,  32'hCAFE_F00D, 1'b1);
        drive("R9", 2'd2, 1'b1, 5'd7,  8'd0,  32'h8765_4321, 1'b1);
        drive("R9", 2'd3, 1'b1, 5'd3,  8'd0,  32'h0F0F_0F0F, 1'b0);
        // R10
        drive("R10", 2'd1, 1'b0, 5'd0, 8'd0,  32'h8000_0001, 1'b0);
        drive("R10", 2'd2, 1'b0, 5'd0, 8'd0,  32'h8000_0000, 1'b0);
        // R11
        drive("R11", 2'd0, 1'b1, 5'd0, 8'd32, 32'h0000_0001, 1'b0);
        drive("R11", 2'd1, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
        drive("R11", 2'd0, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1);
        drive("R11", 2'd1, 1'b1, 5'd0, 8'd255, 32'hFFFF_FFFF, 1'b1);
        // R12
        drive("R12", 2'd2, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
        drive("R12", 2'd2, 1'b1, 5'd0, 8'd200, 32'h7FFF_FFFF, 1'b1);
        // R13
        drive("R13", 2'd3, 1'b1, 5'd0, 8'd32, 32'h8000_1234, 1'b0);
        drive("R13", 2'd3, 1'b1, 5'd0, 8'd64, 32'h0000_5678, 1'b1);
        drive("R13", 2'd3, 1'b1, 5'd0, 8'd36, 32'h0000_00F1, 1'b0);

        // R2: idle cycles hold the last result
        idle(1);
        idle(3);
        check("R2", out_result, out_carry, last_res, last_c);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R2: out_valid=%b expected 0", out_valid);
        end

        // R3: random mix over all types and both sources
        for (int k = 0; k < 3000; k++) begin
            drive("R3", 2'($urandom), 1'($urandom), 5'($urandom), 8'($urandom),
                  $urandom, 1'($urandom));
            if (($urandom % 8) == 0) idle(1 + ($urandom % 2));
        end
        idle(3);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2: %0d results missing, expected 0", sb_q.size());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule